// File: doc/BRIEF.md
# Two-Level Grouped Interrupt Expander

The expander gathers up to 96 interrupt sources, organised as 12 groups of 8, and reduces them to 12 processor-level request lines. The processor then receives one request and a vector index. Every source position owns a flag bit, which latches a rising edge, and an enable bit. Each group also has an acknowledge latch. Once a group has forwarded a request, the latch holds that group silent until software releases it. Forwarded requests land in a 12-bit processor flag register. That register is qualified by a 12-bit processor enable register and a global mask bit, and the lowest-numbered active line is presented to the processor.

When the processor accepts a request, the expander reports the index `line*8 + source`. On the same edge it clears both the chosen group flag bit and the processor flag bit. A simple register port gives software read and write access to flags, enables, acknowledges and the mask. Writing a group flag raises a software interrupt on an unused position. A software read-modify-write of a group flag register is not atomic, so a peripheral edge that arrives between the read and the write is lost.

Top module: `irq_cascade`

## Requirements
- R1: After reset all group flags, group enables, acknowledge latches, processor flags and processor enables read 0, the global mask reads 1, and `cpu_irq` is 0.
- R2: A 0-to-1 transition on a source bit sets its group flag bit at the next clock edge, even while the group's acknowledge latch is set. A source held at 1 does not set the flag again after the flag has been cleared.
- R3: A group whose acknowledge latch is 0 and which holds at least one enabled, set flag sets its processor flag bit and its acknowledge latch at the next edge. While the latch is 1 the group sets no processor flag. Writing 1 to the latch's bit in the acknowledge register clears it, and flags still pending then trigger the group again.
- R4: A set group flag whose enable bit is 0 never causes a processor flag to be set.
- R5: Within a group, the lowest-numbered enabled set flag is chosen. Across lines, the lowest-numbered line with both flag and enable set is chosen.
- R6: `cpu_irq` is 1 exactly when the mask is 0 and some processor line has both flag and enable set. `cpu_vec` then equals chosen line * 8 + chosen source within that group.
- R7: At an edge where `cpu_irq` and `cpu_ack` are both 1, the chosen group flag bit and the chosen processor flag bit are cleared.
- R8: While the mask is 1, processor flags keep accumulating and `cpu_irq` stays 0. After a write of 0 to the mask, `cpu_irq` is 1 in the following cycle if any line is active.
- R9: A write to a group flag register replaces its whole content. Writing 1 to an enabled position raises an interrupt for that position, and a peripheral flag set between a software read and a write-back of that register is lost.
- R10: Register map (word addresses), with reads combinational on `bus_rdata`:
  - 0+g: group g flags.
  - 16+g: group g enables.
  - 32: acknowledge latches (a write of 1 clears a bit).
  - 33: processor flags.
  - 34: processor enables.
  - 35: global mask in bit 0.
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 96 | Peripheral request levels, bit g*8+s is source s of group g |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 12 | Register write data |
| bus_rdata | output | 12 | Register read data for `bus_addr` |
| cpu_irq | output | 1 | Request to the processor |
| cpu_vec | output | 7 | Vector index of the presented request |
| cpu_ack | input | 1 | Processor accepts the presented request |

## Verification
The assertions take several things for granted. `cpu_ack` is only raised while `cpu_irq` is high. Software alone clears acknowledge latches and rewrites flags, so any drop of a group flag or an acknowledge bit must coincide with a bus write or an acceptance. Source bits are taken as already synchronous to `clk`. The stimulus respects all of this: it changes sources and bus fields only on falling edges, raises `cpu_ack` only after it has seen `cpu_irq` high, and holds every acceptance to a single cycle.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int NUM_GRP_DEF = 12;
    localparam int GRP_W_DEF   = 8;
    localparam int ADDR_W      = 6;

    localparam logic [ADDR_W-1:0] A_ACK  = 6'd32;
    localparam logic [ADDR_W-1:0] A_CPUF = 6'd33;
    localparam logic [ADDR_W-1:0] A_CPUE = 6'd34;
    localparam logic [ADDR_W-1:0] A_MASK = 6'd35;

    typedef enum logic [2:0] {
        RK_GFLAG, RK_GEN, RK_ACK, RK_CPUF, RK_CPUE, RK_MASK, RK_NONE
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t   kind;
        logic [3:0]  idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a, input int n);
        reg_dec_t d;
        d.idx  = a[3:0];
        d.kind = RK_NONE;
        case (a[5:4])
            2'd0: if (int'(a[3:0]) < n) d.kind = RK_GFLAG;
            2'd1: if (int'(a[3:0]) < n) d.kind = RK_GEN;
            2'd2: begin
                case (a)
                    A_ACK:   d.kind = RK_ACK;
                    A_CPUF:  d.kind = RK_CPUF;
                    A_CPUE:  d.kind = RK_CPUE;
                    A_MASK:  d.kind = RK_MASK;
                    default: d.kind = RK_NONE;
                endcase
            end
            default: d.kind = RK_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irqx_prio.sv
module irqx_prio #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqx_group.sv
module irqx_group #(
    parameter int W  = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  src_i,
    input  logic          flag_we,
    input  logic          en_we,
    input  logic          ack_clr,
    input  logic [W-1:0]  wdata,
    input  logic          take_i,
    input  logic [IW-1:0] take_sel,
    output logic [W-1:0]  flag_o,
    output logic [W-1:0]  en_o,
    output logic          ack_o,
    output logic          pulse_o,
    output logic [IW-1:0] sel_o
);
    logic [W-1:0] src_q, flag_q, en_q, flag_n, rise, pend;
    logic         ack_q, any_pend;

    assign rise = src_i & ~src_q;
    assign pend = flag_q & en_q;

    irqx_prio #(.W(W)) u_prio (.req(pend), .vld(any_pend), .idx(sel_o));

    // forward one request, then stay quiet until software releases the latch
    assign pulse_o = ~ack_q & any_pend;

    always_comb begin
        flag_n = flag_we ? wdata : flag_q;
        if (take_i) flag_n[take_sel] = 1'b0;
        flag_n = flag_n | rise;          // a source edge beats any clear
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            flag_q <= '0;
            en_q   <= '0;
            ack_q  <= 1'b0;
        end else begin
            src_q  <= src_i;
            flag_q <= flag_n;
            if (en_we) en_q <= wdata;
            if (pulse_o)      ack_q <= 1'b1;
            else if (ack_clr) ack_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign ack_o  = ack_q;
endmodule

// File: rtl/irqx_cpu.sv
module irqx_cpu #(
    parameter int N  = 12,
    localparam int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pulse_i,
    input  logic          flag_we,
    input  logic          en_we,
    input  logic          mask_we,
    input  logic [N-1:0]  wdata,
    input  logic          accept_i,
    output logic [N-1:0]  flag_o,
    output logic [N-1:0]  en_o,
    output logic          mask_o,
    output logic          irq_o,
    output logic [LW-1:0] line_o
);
    logic [N-1:0] flag_q, en_q, flag_n, act;
    logic         mask_q, any_act;

    assign act = flag_q & en_q;

    irqx_prio #(.W(N)) u_prio (.req(act), .vld(any_act), .idx(line_o));

    assign irq_o = ~mask_q & any_act;

    always_comb begin
        flag_n = flag_we ? wdata : flag_q;
        if (accept_i) flag_n[line_o] = 1'b0;
        flag_n = flag_n | pulse_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            en_q   <= '0;
            mask_q <= 1'b1;
        end else begin
            flag_q <= flag_n;
            if (en_we)   en_q   <= wdata;
            if (mask_we) mask_q <= wdata[0];
        end
    end

    assign flag_o = flag_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
    import irqx_pkg::*;
#(
    parameter int NUM_GRP = NUM_GRP_DEF,
    parameter int GRP_W   = GRP_W_DEF,
    localparam int NSRC   = NUM_GRP * GRP_W,
    localparam int DATA_W = (NUM_GRP > GRP_W) ? NUM_GRP : GRP_W,
    localparam int VEC_W  = $clog2(NSRC),
    localparam int SEL_W  = (GRP_W > 1) ? $clog2(GRP_W) : 1,
    localparam int LINE_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq,
    output logic [VEC_W-1:0]  cpu_vec,
    input  logic              cpu_ack
);
    reg_dec_t            dec;
    logic [GRP_W-1:0]    grp_flag [NUM_GRP];
    logic [GRP_W-1:0]    grp_en   [NUM_GRP];
    logic [SEL_W-1:0]    grp_sel  [NUM_GRP];
    logic [NSRC-1:0]     grp_flag_all;
    logic [NUM_GRP-1:0]  grp_ack_all, grp_pulse;
    logic [NUM_GRP-1:0]  cpu_flag, cpu_en;
    logic                gmask, accept;
    logic [LINE_W-1:0]   cpu_line;
    logic [SEL_W-1:0]    win_sel;

    assign dec    = decode_addr(bus_addr, NUM_GRP);
    assign accept = cpu_irq & cpu_ack;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic hit;
        assign hit = (dec.idx == 4'(g));
        irqx_group #(.W(GRP_W)) u_grp (
            .clk      (clk),
            .rst      (rst),
            .src_i    (src_i[g*GRP_W +: GRP_W]),
            .flag_we  (bus_we && dec.kind == RK_GFLAG && hit),
            .en_we    (bus_we && dec.kind == RK_GEN && hit),
            .ack_clr  (bus_we && dec.kind == RK_ACK && bus_wdata[g]),
            .wdata    (bus_wdata[GRP_W-1:0]),
            .take_i   (accept && cpu_line == LINE_W'(g)),
            .take_sel (win_sel),
            .flag_o   (grp_flag[g]),
            .en_o     (grp_en[g]),
            .ack_o    (grp_ack_all[g]),
            .pulse_o  (grp_pulse[g]),
            .sel_o    (grp_sel[g])
        );
        assign grp_flag_all[g*GRP_W +: GRP_W] = grp_flag[g];
    end

    irqx_cpu #(.N(NUM_GRP)) u_cpu (
        .clk      (clk),
        .rst      (rst),
        .pulse_i  (grp_pulse),
        .flag_we  (bus_we && dec.kind == RK_CPUF),
        .en_we    (bus_we && dec.kind == RK_CPUE),
        .mask_we  (bus_we && dec.kind == RK_MASK),
        .wdata    (bus_wdata[NUM_GRP-1:0]),
        .accept_i (accept),
        .flag_o   (cpu_flag),
        .en_o     (cpu_en),
        .mask_o   (gmask),
        .irq_o    (cpu_irq),
        .line_o   (cpu_line)
    );

    assign win_sel = grp_sel[cpu_line];
    assign cpu_vec = VEC_W'(cpu_line) * VEC_W'(GRP_W) + VEC_W'(win_sel);

    always_comb begin
        case (dec.kind)
            RK_GFLAG: bus_rdata = DATA_W'(grp_flag[dec.idx]);
            RK_GEN:   bus_rdata = DATA_W'(grp_en[dec.idx]);
            RK_ACK:   bus_rdata = DATA_W'(grp_ack_all);
            RK_CPUF:  bus_rdata = DATA_W'(cpu_flag);
            RK_CPUE:  bus_rdata = DATA_W'(cpu_en);
            RK_MASK:  bus_rdata = DATA_W'(gmask);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk
    import irqx_pkg::*;
#(
    parameter int NUM_GRP = 12,
    parameter int GRP_W   = 8,
    localparam int NSRC   = NUM_GRP * GRP_W,
    localparam int VEC_W  = $clog2(NSRC),
    localparam int LINE_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               cpu_irq,
    input logic               cpu_ack,
    input logic [VEC_W-1:0]   cpu_vec,
    input logic [NSRC-1:0]    grp_flag_all,
    input logic [NUM_GRP-1:0] grp_ack_all,
    input logic [NUM_GRP-1:0] cpu_flag,
    input logic [NUM_GRP-1:0] cpu_en,
    input logic               gmask
);
    logic [LINE_W-1:0] line_w;
    assign line_w = LINE_W'(cpu_vec / VEC_W'(GRP_W));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        gmask |-> !cpu_irq);

    p_vec_points_active_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (cpu_flag[line_w] && cpu_en[line_w]));

    p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_ACK) |=> (($past(grp_ack_all) & ~grp_ack_all) == '0));

    p_cpu_set_gated_r3: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == A_CPUF)
        |=> ((cpu_flag & ~$past(cpu_flag) & ~(grp_ack_all & ~$past(grp_ack_all))) == '0));

    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_we && !(cpu_irq && cpu_ack)) |=> (($past(grp_flag_all) & ~grp_flag_all) == '0));

    p_accept_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq && cpu_ack && !bus_we && grp_ack_all[line_w]) |=> !cpu_flag[$past(line_w)]);

    p_ack_only_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> cpu_irq);
endmodule

bind irq_cascade irqx_chk #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .cpu_irq      (cpu_irq),
    .cpu_ack      (cpu_ack),
    .cpu_vec      (cpu_vec),
    .grp_flag_all (grp_flag_all),
    .grp_ack_all  (grp_ack_all),
    .cpu_flag     (cpu_flag),
    .cpu_en       (cpu_en),
    .gmask        (gmask)
);

// File: tb/irq_cascade_bench.sv
module irq_cascade_bench;
    localparam int NSRC = 96;
    localparam int DW   = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic           bus_we = 1'b0;
    logic [5:0]     bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           cpu_irq;
    logic [6:0]     cpu_vec;
    logic           cpu_ack = 1'b0;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    irq_cascade u_irq_cascade (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = DW'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_addr = 6'(a);
        #1 v = int'(bus_rdata);
    endtask

    task automatic rdchk(input string tag, input int a, input int exp);
        int v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse_src(input logic [NSRC-1:0] m);
        @(negedge clk); src_i = src_i | m;
        @(negedge clk); src_i = src_i & ~m;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side of the scoreboard: wait for a request, queue the expectation, accept
    task automatic take_irq(input int exp, input string tag);
        int k;
        k = 0;
        @(negedge clk);
        while (!cpu_irq && k < 10) begin
            @(negedge clk);
            k++;
        end
        if (!cpu_irq) begin
            chk({tag, " request expected"}, 0, 1);
        end else begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
            cpu_ack = 1'b1;
            @(posedge clk);
            #1 cpu_ack = 1'b0;
        end
    endtask

    // monitor side: compare the vector on every accepted cycle
    always begin
        @(negedge clk);
        #1;
        if (cpu_ack) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected acceptance", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " cpu_irq at accept"}, int'(cpu_irq), 1);
                chk({t, " cpu_vec"}, int'(cpu_vec), e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 cpu_irq after reset", int'(cpu_irq), 0);
        rdchk("R1 group0 flags", 0, 0);
        rdchk("R1 group0 enables", 16, 0);
        rdchk("R1 ack latches", 32, 0);
        rdchk("R1 cpu flags", 33, 0);
        rdchk("R1 cpu enables", 34, 0);
        rdchk("R1 mask", 35, 1);

        // setup and R10 register map readback
        wr(16 + 0, 'h01);  wr(16 + 1, 'hFF); wr(16 + 2, 'hFF); wr(16 + 4, 'hFF);
        wr(16 + 5, 'h80);  wr(16 + 6, 'h10); wr(16 + 11, 'h80);
        wr(34, 'hFFF);
        rdchk("R10 cpu enable readback", 34, 'hFFF);
        rdchk("R10 group11 enable readback", 16 + 11, 'h80);
        rdchk("R10 unmapped address", 40, 0);

        // R2/R3/R8: edge on group 2 source 5, held high, mask still set
        @(negedge clk); src_i[21] = 1'b1;
        settle(4);
        rdchk("R2 group2 flag from edge", 2, 'h20);
        rdchk("R3 cpu flag line2", 33, 'h004);
        rdchk("R3 ack latch group2", 32, 'h004);
        chk("R8 masked no request", int'(cpu_irq), 0);
        wr(35, 0);
        chk("R8 request cycle after unmask", int'(cpu_irq), 1);
        take_irq(21, "R6 group2 src5");
        settle(2);
        rdchk("R7 group2 flag cleared, R2 held level no reset", 2, 0);
        rdchk("R7 cpu flag cleared", 33, 0);
        @(negedge clk); src_i[21] = 1'b0;

        // R3 blocking by acknowledge latch, then release
        pulse_src(NSRC'(1) << 17);
        settle(3);
        rdchk("R2 flag sets while blocked", 2, 'h02);
        rdchk("R3 no cpu flag while latched", 33, 0);
        chk("R3 no request while latched", int'(cpu_irq), 0);
        wr(32, 'h004);
        take_irq(17, "R3 retrigger after ack");

        // R5/R8 priority with accumulation under mask
        wr(35, 1);
        pulse_src((NSRC'(1) << 0) | (NSRC'(1) << 15) | (NSRC'(1) << 35) | (NSRC'(1) << 38));
        settle(3);
        chk("R8 accumulate no request", int'(cpu_irq), 0);
        rdchk("R8 accumulated cpu flags", 33, 'h013);
        wr(35, 0);
        chk("R8 release after unmask", int'(cpu_irq), 1);
        take_irq(0,  "R5 line0 first");
        take_irq(15, "R5 line1 next");
        take_irq(35, "R5 lowest source in group4");
        settle(2);
        chk("R3 group4 latched with pending bit6", int'(cpu_irq), 0);
        wr(32, 'h010);
        take_irq(38, "R3 pending flag retriggers");

        // R4 disabled position
        pulse_src(NSRC'(1) << 24);
        settle(3);
        rdchk("R4 flag set while disabled", 3, 'h01);
        rdchk("R4 no cpu flag while disabled", 33, 0);
        wr(16 + 3, 'h01);
        take_irq(24, "R4 enable releases");

        // R9 software interrupt on highest position
        wr(11, 'h80);
        take_irq(95, "R9 software interrupt");

        // R9 read-modify-write loses a peripheral edge
        rd(6, v);
        chk("R9 group6 initial", v, 0);
        pulse_src(NSRC'(1) << 50);
        settle(1);
        rdchk("R2 group6 peripheral flag", 6, 'h04);
        wr(6, v | 'h10);
        rdchk("R9 peripheral flag lost by write-back", 6, 'h10);
        take_irq(52, "R9 software bit after write-back");

        settle(4);
        chk("R6 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule